// File: doc/BRIEF.md
# Serial Channel Interrupt Vector Register

This block sits beside a bank of serial channels. Each channel has a raw interrupt and an enable bit held in that channel's modem control register. The block merges all enabled requests onto one active-low host interrupt line, and that line is gated by a global enable. The channels live in 8-byte windows of a host byte-wide I/O space. The top byte of the last channel in every group of four is taken over by a vector register for that group.

Each channel's request is captured in a pending latch. A service routine reads the vector register of a group and sees, active-low, which of its four channels asked for service. The read also releases every latch whose source has gone quiet. The routine reads again before it exits, to catch requests that arrived during service.

The first vector register also holds two control fields that are written by the host: the global interrupt enable and a two-bit reference clock selection that goes to the channels. The block also tells the surrounding logic whether each host byte access targets a vector register or a channel window, and if a channel window, which channel.

Top module: `uivr_top`

## Requirements
- R1: A host access is a vector register hit only when address bits [2:0] are 111 and bits [4:3] are 11. This means offsets 0x1F and 0x3F with eight channels. `vec_hit` is 1 for such an access, and `vec_sel` gives address bits above bit 4 (0 for 0x1F, 1 for 0x3F).
- R2: Any other read or write asserts `chan_cs`, with `chan_idx` equal to address bits [5:3]. `chan_cs` is 0 on a vector hit and when no access is made.
- R3: A request that is raised (`ch_irq` bit 1) while its channel is enabled (`ch_irq_dis` bit 0) is latched at the next clock edge. In a read of vector register k, bit j shows channel 4k+j: 0 means pending and 1 means none.
- R4: A request raised while `ch_irq_dis` for its channel is 1 is not latched. Its read bit stays 1 and `host_irq_n` stays high.
- R5: A read of a vector register clears a latched bit only if that channel's enabled source is low during the read cycle. A source that is still active keeps its bit at 0.
- R6: Read data bits D7..D4 of a vector register are always 0.
- R7: `host_irq_n` is low exactly when the global enable is 1 and at least one latched channel is currently enabled. It goes high in the same cycle that the last such latch clears.
- R8: A write to offset 0x1F loads the global enable from D7, where 1 enables. The global enable is 0 after reset.
- R9: A write to offset 0x1F loads `clk_sel` from D1..D0: 00 = 1.8432 MHz, 01 = 3.6864 MHz, 10 = 7.3728 MHz, 11 = 14.7456 MHz. A write to 0x3F changes neither `clk_sel` nor the global enable.
- R10: Synchronous active-low reset sets `clk_sel` to 00, clears every latch (all read bits become 1) and clears the global enable.
- R11: Reading one vector register never clears a latch that belongs to the other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_irq | input | NUM_CH | Raw interrupt from each channel |
| ch_irq_dis | input | NUM_CH | Per-channel disable (modem control D2), 1 = disabled |
| host_addr | input | ADDR_W | Byte offset inside the host I/O window |
| host_rd | input | 1 | Byte read strobe, one cycle |
| host_wr | input | 1 | Byte write strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Vector register read data, 0 when not a vector hit |
| vec_hit | output | 1 | Current access targets a vector register |
| vec_sel | output | VSEL_W | Which vector register is hit |
| chan_cs | output | 1 | Current access targets a channel window |
| chan_idx | output | CH_W | Channel addressed by the access |
| clk_sel | output | 2 | Reference clock selection to the channels |
| global_en | output | 1 | Global interrupt enable |
| host_irq_n | output | 1 | Merged active-low host interrupt |

## Verification
The assertions check on every cycle that:
- an enabled request is always captured on the next cycle;
- a latch never sets without a request and never drops without a read;
- a read while the source is active cannot clear a latch;
- the global enable follows each write to the first vector register;
- the host line stays high while the global enable is off;
- a vector hit never also selects a channel window.

Only the bench scenarios show the end-to-end behaviour. These are:
- the active-low encoding of the read bits;
- the full address decode over the whole window;
- the two-read service sequence;
- the isolation of one group's latches from the other group's reads;
- the clock selection codes;
- the effect of masking a channel whose latch is already set.

// File: rtl/uivr_pkg.sv
// Package: shared constants and types for the interrupt vector register block.
// Assumes channels come in groups of four, each channel owning an 8-byte window.
package uivr_pkg;
    localparam int WIN_BYTES = 8;
    localparam int GROUP_CH  = 4;
    localparam int OFF_W     = 3;   // address bits inside one channel window
    localparam int GRP_W     = 2;   // address bits selecting a channel within a group

    typedef enum logic [1:0] {
        REFCLK_X1 = 2'b00,
        REFCLK_X2 = 2'b01,
        REFCLK_X4 = 2'b10,
        REFCLK_X8 = 2'b11
    } refclk_e;
endpackage

// File: rtl/uivr_decode.sv
// Module: host byte address decoder.
// Splits each host access into either a vector register hit (top byte of the
// last channel in a group of four) or a channel window select.
// Assumes single-cycle rd/wr strobes and byte-wide accesses only.
module uivr_decode #(
    parameter int NUM_CH  = 8,
    parameter int ADDR_W  = 6,
    parameter int CH_W    = 3,
    parameter int NUM_VEC = 2,
    parameter int VSEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              vec_hit,
    output logic [VSEL_W-1:0] vec_sel,
    output logic              chan_cs,
    output logic [CH_W-1:0]   chan_idx,
    output logic [NUM_VEC-1:0] rd_hit,
    output logic [NUM_VEC-1:0] wr_hit
);
    import uivr_pkg::*;

    logic is_vec_addr;
    logic access;

    // Recognise the reserved top byte of the last channel of a group.
    always_comb begin
        is_vec_addr = (&addr[OFF_W-1:0]) && (&addr[OFF_W+GRP_W-1:OFF_W]);
        access      = rd | wr;
        vec_hit     = access && is_vec_addr;
        chan_cs     = access && !is_vec_addr;
        chan_idx    = addr[ADDR_W-1:OFF_W];
    end

    // Extract the group number; a single group needs no address bits.
    generate
        if (NUM_VEC > 1) begin : g_multi
            always_comb vec_sel = addr[ADDR_W-1:OFF_W+GRP_W];
        end else begin : g_single
            always_comb vec_sel = '0;
        end
    endgenerate

    // Per-group strobes for the pending latches and control registers.
    always_comb begin
        for (int g = 0; g < NUM_VEC; g++) begin
            rd_hit[g] = rd && is_vec_addr && (32'(vec_sel) == g);
            wr_hit[g] = wr && is_vec_addr && (32'(vec_sel) == g);
        end
    end

    // R2
    hit_excludes_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_hit |-> !chan_cs);
    // R1
    hit_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hit) && $onehot0(wr_hit));
endmodule

// File: rtl/uivr_pend_group.sv
// Module: pending latches for one group of four channels.
// A latch sets when its enabled source is high. A read of the group's vector
// register clears every latch whose source is low in that cycle. Setting wins.
module uivr_pend_group #(
    parameter int GCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [GCH-1:0] src,
    input  logic           rd_hit,
    output logic [GCH-1:0] pend
);
    // Capture requests and release quiet latches on a vector read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (rd_hit) begin
            pend <= src;
        end else begin
            pend <= pend | src;
        end
    end

    generate
        for (genvar j = 0; j < GCH; j++) begin : g_chk
            // R3
            req_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
                src[j] |=> pend[j]);
            // R4
            no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!pend[j] && !src[j]) |=> !pend[j]);
            // R5
            hold_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[j] && !rd_hit) |=> pend[j]);
            // R5
            clear_on_quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_hit && !src[j]) |=> !pend[j]);
        end
    endgenerate
endmodule

// File: rtl/uivr_ctrl.sv
// Module: host-written control fields of the first vector register.
// Holds the global interrupt enable (D7) and the reference clock select (D1..D0).
module uivr_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    output logic       global_en,
    output logic [1:0] clk_sel
);
    import uivr_pkg::*;

    refclk_e sel_q;

    // Load the control fields on a write to the first vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            global_en <= 1'b0;
            sel_q     <= REFCLK_X1;
        end else if (wr_hit) begin
            global_en <= wdata[7];
            sel_q     <= refclk_e'(wdata[1:0]);
        end
    end

    always_comb clk_sel = sel_q;

    // R8
    gie_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (global_en == $past(wdata[7])));
    // R9
    sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(clk_sel));
    // R9: the unused data bits D6..D2 are reserved and must stay known
    reserved_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |-> !$isunknown(wdata[6:2]));
endmodule

// File: rtl/uivr_top.sv
// Module: interrupt vector register for a bank of serial channels.
// Merges the enabled channel requests onto one active-low host line, reports
// pending channels active-low per group of four, and decodes host accesses.
// Assumes NUM_CH is a multiple of four and that the host uses byte accesses only.
module uivr_top #(
    parameter int NUM_CH  = 8,
    parameter int CH_W    = $clog2(NUM_CH),
    parameter int ADDR_W  = CH_W + 3,
    parameter int NUM_VEC = NUM_CH / 4,
    parameter int VSEL_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_irq,
    input  logic [NUM_CH-1:0] ch_irq_dis,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              vec_hit,
    output logic [VSEL_W-1:0] vec_sel,
    output logic              chan_cs,
    output logic [CH_W-1:0]   chan_idx,
    output logic [1:0]        clk_sel,
    output logic              global_en,
    output logic              host_irq_n
);
    import uivr_pkg::*;

    logic [NUM_VEC-1:0] rd_hit;
    logic [NUM_VEC-1:0] wr_hit;
    logic [NUM_CH-1:0]  src;
    logic [NUM_CH-1:0]  pend;

    uivr_decode #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W),
        .NUM_VEC(NUM_VEC), .VSEL_W(VSEL_W)
    ) u_decode (
        .clk(clk), .rst_n(rst_n),
        .addr(host_addr), .rd(host_rd), .wr(host_wr),
        .vec_hit(vec_hit), .vec_sel(vec_sel),
        .chan_cs(chan_cs), .chan_idx(chan_idx),
        .rd_hit(rd_hit), .wr_hit(wr_hit)
    );

    uivr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(wr_hit[0]), .wdata(host_wdata),
        .global_en(global_en), .clk_sel(clk_sel)
    );

    // Qualify each raw request with its channel enable.
    always_comb src = ch_irq & ~ch_irq_dis;

    generate
        for (genvar g = 0; g < NUM_VEC; g++) begin : g_grp
            uivr_pend_group #(.GCH(GROUP_CH)) u_pend (
                .clk(clk), .rst_n(rst_n),
                .src(src[g*GROUP_CH +: GROUP_CH]),
                .rd_hit(rd_hit[g]),
                .pend(pend[g*GROUP_CH +: GROUP_CH])
            );
        end
    endgenerate

    // Return the addressed group's latches active-low; reserved bits read 0.
    always_comb begin
        host_rdata = '0;
        for (int g = 0; g < NUM_VEC; g++) begin
            if (vec_hit && (32'(vec_sel) == g))
                host_rdata = {4'b0000, ~pend[g*GROUP_CH +: GROUP_CH]};
        end
    end

    // Drive the shared host line from enabled latches under the global enable.
    always_comb host_irq_n = !(global_en && |(pend & ~ch_irq_dis));

    // R7
    irq_quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |-> host_irq_n);
    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[7:4] == 4'b0000);
endmodule

// File: tb/uivr_top_tb.sv
module uivr_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ch_irq = '0;
    logic [7:0] ch_irq_dis = '0;
    logic [5:0] host_addr = '0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       vec_hit;
    logic [0:0] vec_sel;
    logic       chan_cs;
    logic [2:0] chan_idx;
    logic [1:0] clk_sel;
    logic       global_en;
    logic       host_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    uivr_top u_dut (
        .clk(clk), .rst_n(rst_n), .ch_irq(ch_irq), .ch_irq_dis(ch_irq_dis),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .vec_hit(vec_hit),
        .vec_sel(vec_sel), .chan_cs(chan_cs), .chan_idx(chan_idx),
        .clk_sel(clk_sel), .global_en(global_en), .host_irq_n(host_irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-cycle vector read; data sampled before the clearing edge.
    task automatic vread(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic vwrite(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        ch_irq = m;
        @(negedge clk);
        ch_irq = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        ch_irq = '0; ch_irq_dis = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        vwrite(6'h1F, 8'h83);
        pulse(8'hFF);
        do_reset();
        chk("R10 clk_sel", clk_sel, 2'b00);
        chk("R10 global_en", global_en, 0);
        chk("R10 irq", host_irq_n, 1);
        vread(6'h1F, d); chk("R10 grp0", d, 8'h0F);
        vread(6'h3F, d); chk("R10 grp1", d, 8'h0F);
    endtask

    task automatic t_decode();
        int bad_hit = 0;
        int bad_cs = 0;
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            host_addr = 6'(a); host_rd = (a % 2 == 0); host_wr = (a % 2 == 1);
            #1;
            if (vec_hit !== (a == 8'h1F || a == 8'h3F)) bad_hit++;
            if (vec_hit && vec_sel !== 1'(a >> 5)) bad_hit++;
            if (chan_cs !== !(a == 8'h1F || a == 8'h3F)) bad_cs++;
            if (chan_idx !== 3'(a >> 3)) bad_cs++;
            host_rd = 1'b0; host_wr = 1'b0;
        end
        chk("R1 vector hit decode", bad_hit, 0);
        chk("R2 channel select decode", bad_cs, 0);
        @(negedge clk); #1;
        chk("R2 idle cs", chan_cs, 0);
        chk("R2 idle hit", vec_hit, 0);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        do_reset();
        pulse(8'b0010_0100);    // ch3 (grp0 bit2), ch6 (grp1 bit1)
        vread(6'h1F, d); chk("R3 grp0 bit", d, 8'h0B);
        chk("R6 reserved", d[7:4], 0);
        vread(6'h1F, d); chk("R5 cleared after quiet read", d, 8'h0F);
        vread(6'h3F, d); chk("R11 grp1 untouched", d, 8'h0D);
        vread(6'h3F, d); chk("R5 grp1 cleared", d, 8'h0F);
    endtask

    task automatic t_masked();
        logic [7:0] d;
        do_reset();
        vwrite(6'h1F, 8'h80);
        @(negedge clk); ch_irq_dis = 8'h01;
        pulse(8'h01);
        #1 chk("R4 irq stays high", host_irq_n, 1);
        vread(6'h1F, d); chk("R4 masked not latched", d, 8'h0F);
        @(negedge clk); ch_irq_dis = '0;
    endtask

    task automatic t_active_read();
        logic [7:0] d;
        do_reset();
        @(negedge clk); ch_irq = 8'h02;
        vread(6'h1F, d); chk("R5 active read", d, 8'h0D);
        vread(6'h1F, d); chk("R5 kept while active", d, 8'h0D);
        @(negedge clk); ch_irq = '0;
        vread(6'h1F, d); chk("R5 latched after drop", d, 8'h0D);
        vread(6'h1F, d); chk("R5 cleared", d, 8'h0F);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        do_reset();
        pulse(8'h40);
        #1 chk("R7 gated by global", host_irq_n, 1);
        vwrite(6'h1F, 8'h80);
        #1 chk("R8 enable set", global_en, 1);
        chk("R7 asserted", host_irq_n, 0);
        @(negedge clk); ch_irq_dis = 8'h40;
        #1 chk("R7 masked latch", host_irq_n, 1);
        @(negedge clk); ch_irq_dis = '0;
        #1 chk("R7 re-asserted", host_irq_n, 0);
        vread(6'h3F, d);
        #1 chk("R7 released after clear", host_irq_n, 1);
        vwrite(6'h1F, 8'h00);
        #1 chk("R8 enable cleared", global_en, 0);
    endtask

    task automatic t_clksel();
        for (int s = 0; s < 4; s++) begin
            vwrite(6'h1F, 8'h80 | 8'(s));
            #1 chk("R9 clk_sel", clk_sel, 32'(s));
        end
        vwrite(6'h3F, 8'h01);
        #1 chk("R9 grp1 write sel", clk_sel, 2'b11);
        chk("R9 grp1 write gie", global_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_latch();
        t_masked();
        t_active_read();
        t_irq();
        t_clksel();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule